// File: doc/BRIEF.md
# GPIO Output Set/Clear Register Bank

This block owns the output side of an 81-pin general-purpose I/O port. The pins are grouped into three banks of up to 32 pins. Each pin has an output level latch and a direction bit. Software never writes the level latch directly. It writes a one to a bit of a bank's set register to raise that pin's latch, or a one to a bit of the bank's clear register to lower it. Zero bits in either write leave their pins alone, so several drivers can share the port without a read-modify-write.

The direction register of each bank can be read and written, and a 1 makes the pin an output. A pin that is an input does not drive its pad. Its latch still takes set and clear writes, and the stored level shows on the pad on the same clock edge on which the pin becomes an output.

The register port is a plain synchronous bus with byte address, write strobe, write data and combinational read data. It has no back-pressure: every strobed write is accepted on the next rising clock edge. Input sampling, alternate functions and interrupts belong to other blocks.

Top module: `gpio_setclr_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first write, every `pad_oe` and `pad_out` bit is 0 and every direction register reads 0.
- R2: A write to a set register (bank 0 at 0x18, bank 1 at 0x1C, bank 2 at 0x20) puts a 1 in the latch of each pin whose data bit is 1. Each such pin that is an output drives `pad_out` high.
- R3: A write to a clear register (bank 0 at 0x24, bank 1 at 0x28, bank 2 at 0x2C) puts a 0 in the latch of each pin whose data bit is 1, and `pad_out` of that pin goes low.
- R4: Data bits that are 0 in a set or clear write leave their pins' latch and pad level unchanged.
- R5: A set or clear write to an input pin changes its latch, but that pin's `pad_out` stays 0 while the pin is an input. When the pin's direction bit goes to 1, `pad_out` shows the stored level on the same edge as `pad_oe` rises.
- R6: The direction registers (bank 0 at 0x0C, bank 1 at 0x10, bank 2 at 0x14) are read and written at their addresses, with 1 meaning output. `pad_oe` of each pin equals its direction bit.
- R7: Bank 0 maps data bit i to pin i. Bank 1 maps data bit i to pin 32+i. Bank 2 maps data bits 16:0 to pins 64 to 80.
- R8: Data bits 31:17 of any bank-2 write have no effect, and bits 31:17 of the bank-2 direction read are 0.
- R9: A cycle with `bus_we` low, or a write to an address outside the nine mapped word addresses (including one not aligned to a word), changes no pin state.
- R10: A write takes effect on the rising edge where `bus_we` is sampled high. The outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`; direction registers only, other addresses return 0 |
| pad_out | output | 81 | Level driven to each pad (0 while the pin is an input) |
| pad_oe | output | 81 | Output enable for each pad |

## Verification
Two functions can land on one pin at the same clock edge. One is the direction write that turns the pin into an output. The other is the reveal of a level that was latched while the pin was an input. The bench sets bit 20 of bank 0 while that pin is an input and confirms the pad stays low. It then writes the direction register on the very next cycle and requires `pad_out` and `pad_oe` of pin 20 to rise together on that edge. Read-back of the set and clear addresses is a don't-care and is never judged.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int BANK_STRIDE = 4;

  // Base byte addresses of the three register groups; bank b sits at base + 4*b
  localparam int DIR_BASE = 'h0C;
  localparam int SET_BASE = 'h18;
  localparam int CLR_BASE = 'h24;

  // Per-bank write strobes produced by the address decoder
  typedef struct packed {
    logic dir_wr;
    logic set_wr;
    logic clr_wr;
  } bank_strobe_t;

  function automatic int bank_count(input int pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction

  function automatic int bank_width(input int pins, input int b);
    int nb;
    nb = bank_count(pins);
    return (b == nb - 1) ? pins - WORD_W * (nb - 1) : WORD_W;
  endfunction

endpackage

// File: rtl/gpio_setclr_decode.sv
module gpio_setclr_decode
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output bank_strobe_t      strobe [NUM_BANKS],
  output logic [NUM_BANKS-1:0] rd_hit
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_BASE + BANK_STRIDE * b);
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_BASE + BANK_STRIDE * b);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_BASE + BANK_STRIDE * b);

    logic dir_match, set_match, clr_match;

    always_comb begin
      dir_match = (addr == DIR_A);
      set_match = (addr == SET_A);
      clr_match = (addr == CLR_A);
      strobe[b].dir_wr = we & dir_match;
      strobe[b].set_wr = we & set_match;
      strobe[b].clr_wr = we & clr_match;
      rd_hit[b]        = dir_match;
    end
  end

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bank_strobe_t  strobe,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] dir_q,
  output logic [BW-1:0] pad_out,
  output logic [BW-1:0] pad_oe
);

  logic [BW-1:0] lvl_q;
  logic [BW-1:0] lvl_d;

  // Set and clear live at different addresses, so at most one is active
  always_comb begin
    lvl_d = lvl_q;
    if (strobe.set_wr) lvl_d = lvl_q | wdata;
    else if (strobe.clr_wr) lvl_d = lvl_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dir_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (strobe.dir_wr) dir_q <= wdata;
    end
  end

  // An input pin keeps its pending level hidden from the pad
  assign pad_out = lvl_q & dir_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_setclr_rdmux.sv
module gpio_setclr_rdmux
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [NUM_BANKS-1:0] rd_hit,
  input  logic [WORD_W-1:0]    dir_word [NUM_BANKS],
  output logic [WORD_W-1:0]    rdata
);

  // At most one hit, so an OR of gated words is a mux
  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      rdata = rdata | (dir_word[b] & {WORD_W{rd_hit[b]}});
    end
  end

endmodule

// File: rtl/gpio_setclr_top.sv
module gpio_setclr_top
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_PINS = 81
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  localparam int NUM_BANKS = bank_count(NUM_PINS);

  bank_strobe_t           strobe   [NUM_BANKS];
  logic [NUM_BANKS-1:0]   rd_hit;
  logic [WORD_W-1:0]      dir_word [NUM_BANKS];

  gpio_setclr_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .strobe (strobe),
    .rd_hit (rd_hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW = bank_width(NUM_PINS, b);
    logic [BW-1:0] dir_b;

    gpio_setclr_bank #(.BW(BW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (strobe[b]),
      .wdata   (bus_wdata[BW-1:0]),
      .dir_q   (dir_b),
      .pad_out (pad_out[b*WORD_W +: BW]),
      .pad_oe  (pad_oe[b*WORD_W +: BW])
    );

    assign dir_word[b] = WORD_W'(dir_b);
  end

  gpio_setclr_rdmux #(.NUM_BANKS(NUM_BANKS)) u_rdmux (
    .rd_hit   (rd_hit),
    .dir_word (dir_word),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_PINS = 81
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe
);

  localparam int NB    = bank_count(NUM_PINS);
  localparam int LASTW = bank_width(NUM_PINS, NB - 1);
  localparam int LASTL = WORD_W * (NB - 1);
  localparam logic [ADDR_W-1:0] DIR0 = ADDR_W'(DIR_BASE);
  localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(CLR_BASE);
  localparam logic [ADDR_W-1:0] DIRL = ADDR_W'(DIR_BASE + BANK_STRIDE * (NB - 1));

  // R1: reset leaves every pad undriven and low
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0));

  // R2: set bits reach output pins of bank 0
  p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == SET0) |=>
      ((pad_out[WORD_W-1:0] & $past(bus_wdata)) == (pad_oe[WORD_W-1:0] & $past(bus_wdata))));

  // R3: clear bits drive bank-0 pads low
  p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CLR0) |=> ((pad_out[WORD_W-1:0] & $past(bus_wdata)) == '0));

  // R4: zero bits of a bank-0 set write keep their pad level
  p_zero_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == SET0) |=>
      ((pad_out[WORD_W-1:0] & ~$past(bus_wdata)) == ($past(pad_out[WORD_W-1:0]) & ~$past(bus_wdata))));

  // R5: a pin that is an input never drives a high level
  p_input_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == SET0) |=> ((pad_out & ~pad_oe) == '0));

  // R6: bank-0 enables follow a direction write
  p_dir_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DIR0) |=> (pad_oe[WORD_W-1:0] == $past(bus_wdata)));

  // R8: last bank takes only its low data bits
  p_last_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == DIRL) |=> (pad_oe[LASTL +: LASTW] == $past(bus_wdata[LASTW-1:0])));

  // R9: no strobe, no change
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind gpio_setclr_top gpio_setclr_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_setclr_top_tb.sv
`timescale 1ns/1ps
module gpio_setclr_top_tb;

  localparam int NP = 81;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_setclr_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  bank;
    logic [31:0] exp_out;
    logic [31:0] exp_oe;
    logic [3:0]  req;
  } vec_t;

  // Each row: one write, then the expected pad slice of one bank
  localparam vec_t VECS [13] = '{
    '{8'h0C, 32'h0000_00FF, 2'd0, 32'h0000_0000, 32'h0000_00FF, 4'd6},  // R6 dir bank0
    '{8'h18, 32'h0000_0F0F, 2'd0, 32'h0000_000F, 32'h0000_00FF, 4'd2},  // R2 set, bits 8-11 input
    '{8'h24, 32'h0000_0003, 2'd0, 32'h0000_000C, 32'h0000_00FF, 4'd3},  // R3 clear
    '{8'h18, 32'h0000_0000, 2'd0, 32'h0000_000C, 32'h0000_00FF, 4'd4},  // R4 zeros
    '{8'h0C, 32'h0000_FFFF, 2'd0, 32'h0000_0F0C, 32'h0000_FFFF, 4'd5},  // R5 pending revealed
    '{8'h1C, 32'hFFFF_FFFF, 2'd1, 32'h0000_0000, 32'h0000_0000, 4'd5},  // R5 set while input
    '{8'h10, 32'h8000_0001, 2'd1, 32'h8000_0001, 32'h8000_0001, 4'd7},  // R7 bank1 mapping
    '{8'h28, 32'h8000_0000, 2'd1, 32'h0000_0001, 32'h8000_0001, 4'd3},  // R3 bank1 clear
    '{8'h14, 32'hFFFF_FFFF, 2'd2, 32'h0000_0000, 32'h0001_FFFF, 4'd8},  // R8 reserved dir bits
    '{8'h20, 32'hFFFE_0005, 2'd2, 32'h0000_0005, 32'h0001_FFFF, 4'd8},  // R8 reserved set bits
    '{8'h2C, 32'hFFFF_0001, 2'd2, 32'h0000_0004, 32'h0001_FFFF, 4'd7},  // R7 bank2 clear
    '{8'h30, 32'hFFFF_FFFF, 2'd0, 32'h0000_0F0C, 32'h0000_FFFF, 4'd9},  // R9 unmapped
    '{8'h0D, 32'h0000_0000, 2'd0, 32'h0000_0F0C, 32'h0000_FFFF, 4'd9}   // R9 misaligned
  };

  function automatic logic [31:0] slice(input logic [NP-1:0] v, input int b);
    logic [95:0] ext;
    ext = 96'(v);
    return ext[b*32 +: 32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    check("R1 oe in reset", slice(pad_oe, 0) | slice(pad_oe, 1) | slice(pad_oe, 2), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 out after reset", slice(pad_out, 0) | slice(pad_out, 1) | slice(pad_out, 2), 32'h0);
    rd(8'h0C, r); check("R1 dir0 read", r, 32'h0);
    rd(8'h14, r); check("R1 dir2 read", r, 32'h0);

    for (int i = 0; i < 13; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      check($sformatf("R%0d vec%0d out", VECS[i].req, i), slice(pad_out, int'(VECS[i].bank)), VECS[i].exp_out);
      check($sformatf("R%0d vec%0d oe", VECS[i].req, i), slice(pad_oe, int'(VECS[i].bank)), VECS[i].exp_oe);
    end

    // R7 banks stay independent
    check("R7 bank1 after others", slice(pad_out, 1), 32'h0000_0001);
    check("R7 bank2 after others", slice(pad_out, 2), 32'h0000_0004);

    // R10 no change before the sampling edge
    @(negedge clk);
    bus_addr = 8'h24; bus_wdata = 32'h0000_0F00; bus_we = 1'b1;
    #1 check("R10 before edge", slice(pad_out, 0), 32'h0000_0F0C);
    @(posedge clk);
    #1 bus_we = 1'b0;
    check("R10 after edge", slice(pad_out, 0), 32'h0000_000C);

    // R5 set an input pin, then turn it to output on the next cycle
    wr(8'h18, 32'h0010_0000);
    check("R5 pending hidden", slice(pad_out, 0), 32'h0000_000C);
    wr(8'h0C, 32'h0010_FFFF);
    check("R5 revealed out", slice(pad_out, 0), 32'h0010_000C);
    check("R5 revealed oe", slice(pad_oe, 0), 32'h0010_FFFF);

    // R9 strobe low
    @(negedge clk);
    bus_addr = 8'h24; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
    @(posedge clk); #1;
    check("R9 we low", slice(pad_out, 0), 32'h0010_000C);

    // R6 and R8 read-back
    rd(8'h0C, r); check("R6 dir0 read", r, 32'h0010_FFFF);
    rd(8'h10, r); check("R6 dir1 read", r, 32'h8000_0001);
    rd(8'h14, r); check("R8 dir2 read", r, 32'h0001_FFFF);

    // R1 reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 mid reset out", slice(pad_out, 0) | slice(pad_out, 1) | slice(pad_out, 2), 32'h0);
    check("R1 mid reset oe", slice(pad_oe, 0) | slice(pad_oe, 1) | slice(pad_oe, 2), 32'h0);
    rd(8'h10, r); check("R1 mid reset dir1", r, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule